// File: doc/BRIEF.md
# Variable Refresh Raster Timing Generator

This block produces the raster timing for a display panel driver when the refresh rate follows the content. The pixel clock and every horizontal interval are fixed. Each line has the same active span, front porch, sync pulse and back porch. The frame period changes only through the number of whole blanking lines placed after vertical sync and before the first active line. Each line, the block outputs a data-enable, horizontal and vertical sync with selectable polarity, and the active pixel column and row.

After vertical sync, the block counts back porch lines. From the configured minimum onward, it samples a level-sensitive `frame_ready` input at the last cycle of each back porch line. When the input is high there, the next line is the first active line. If no frame is ready by the configured maximum, the block starts the next scan anyway so that the panel refreshes with the previous picture, and it raises `repeat_frame` for that first active line. Consecutive frames can therefore each have a different length, with no gap or resynchronisation between them. A one-cycle `frame_start` marks the first active pixel, and `bp_lines` reports how many back porch lines the latest frame used.

The timing inputs are static. They are changed only while reset is held. The configuration must satisfy these conditions: every horizontal and vertical count is at least 1, and `cfg_vbp_min` ≤ `cfg_vbp_max`.

Top module: `vrr_raster_gen`

## Requirements
- R1: Every line lasts H = cfg_h_active + cfg_h_fp + cfg_h_sync + cfg_h_bp clock cycles. Within a line, data-enable is high on the first cfg_h_active cycles of active lines only. Horizontal sync is active on cycles cfg_h_active + cfg_h_fp through cfg_h_active + cfg_h_fp + cfg_h_sync − 1, counted from the line's first cycle.
- R2: Vertical sync is active for exactly cfg_v_sync whole lines. It changes only at a line start, never while horizontal sync is active. It rises cfg_v_active + cfg_v_fp lines after the first active pixel of the previous frame.
- R3: After vertical sync ends, the active scan starts on the line after the first back porch line n (n ≥ cfg_vbp_min) at whose last cycle frame_ready is high. The first active pixel comes n·H cycles after vertical sync ends, and bp_lines then reads n.
- R4: If frame_ready is already high when the back porch begins, the back porch is exactly cfg_vbp_min lines. If frame_ready rises during a line before the minimum, the back porch is still cfg_vbp_min lines.
- R5: If frame_ready stays low, the back porch ends after cfg_vbp_max lines. bp_lines reads cfg_vbp_max, and repeat_frame is high throughout the first active line of that frame and low from the second line on. If frame_ready is sampled high at line cfg_vbp_max, repeat_frame stays low.
- R6: frame_ready has no effect unless it is high at the last cycle of a back porch line. A pulse wholly inside a line does not shorten the back porch.
- R7: frame_start is high for one cycle, on the first active pixel of each frame, with data-enable high and px_x = px_y = 0.
- R8: px_x counts 0 to cfg_h_active − 1 along the active pixels of a line, and px_y is the active line index 0 to cfg_v_active − 1. Both read 0 whenever data-enable is low.
- R9: For each of cfg_hs_pol and cfg_vs_pol, the value 1 selects active-high and 0 selects active-low for the matching sync output.
- R10: While the synchronous reset is high, data-enable, frame_start and repeat_frame are 0, both syncs are at their inactive level, and px_x, px_y and bp_lines are 0. After reset is released, scanning starts at the first vertical front porch line, so vertical sync first becomes active cfg_v_fp·H + 1 clock edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_h_active | input | CW | Active pixels per line |
| cfg_h_fp | input | CW | Horizontal front porch cycles |
| cfg_h_sync | input | CW | Horizontal sync cycles |
| cfg_h_bp | input | CW | Horizontal back porch cycles |
| cfg_v_active | input | CW | Active lines per frame |
| cfg_v_fp | input | CW | Vertical front porch lines |
| cfg_v_sync | input | CW | Vertical sync lines |
| cfg_vbp_min | input | CW | Fewest back porch lines (fastest refresh) |
| cfg_vbp_max | input | CW | Most back porch lines (slowest refresh) |
| cfg_hs_pol | input | 1 | Horizontal sync polarity, 1 = active high |
| cfg_vs_pol | input | 1 | Vertical sync polarity, 1 = active high |
| frame_ready | input | 1 | New frame available, sampled at back porch line ends |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | CW | Active pixel column |
| px_y | output | CW | Active line index |
| frame_start | output | 1 | Pulse on the first active pixel |
| repeat_frame | output | 1 | High during the first line of a forced refresh |
| bp_lines | output | CW | Back porch lines used by the latest frame |

## Verification
The bench builds the block with CW = 12 and registered outputs (OUT_REG = 1). It uses a small raster of 16 + 3 + 4 + 5 = 28 cycles per line, 6 active lines, 2 front porch lines, 2 sync lines and a back porch between 3 and 8 lines. With this raster, a frame is a few hundred cycles long. The bench can then reach every back porch outcome in a short run: readiness below the minimum, exactly at the minimum, exactly at the maximum, never, and a pulse that misses a line end. The whole sequence is repeated after a reset with both polarities inverted.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

   // Vertical phase of the raster; the order is the scan order.
   typedef enum logic [1:0] {
      VP_FRONT  = 2'd0,
      VP_SYNC   = 2'd1,
      VP_BACK   = 2'd2,
      VP_ACTIVE = 2'd3
   } vphase_e;

   // Single-bit output flags carried together through the output stage.
   typedef struct packed {
      logic de;
      logic hs;
      logic vs;
      logic fs;
      logic rpt;
   } vflags_t;

   localparam vflags_t VFLAGS_IDLE = '{de: 1'b0, hs: 1'b0, vs: 1'b0, fs: 1'b0, rpt: 1'b0};

endpackage

// File: rtl/vrr_line_timer.sv
module vrr_line_timer #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] h_active,
   input  logic [CW-1:0] h_fp,
   input  logic [CW-1:0] h_sync,
   input  logic [CW-1:0] h_bp,
   output logic [CW-1:0] hpos,
   output logic          line_end,
   output logic          in_act,
   output logic          in_sync
);

   // Sums of four CW-bit fields fit in CW+2 bits.
   localparam int SW = CW + 2;

   logic [SW-1:0] hcnt;
   logic [SW-1:0] tot_m1;
   logic [SW-1:0] sync_lo;
   logic [SW-1:0] sync_hi;

   always_comb begin
      sync_lo = SW'(h_active) + SW'(h_fp);
      sync_hi = sync_lo + SW'(h_sync);
      tot_m1  = sync_hi + SW'(h_bp) - SW'(1);
   end

   assign line_end = (hcnt == tot_m1);
   assign in_act   = (hcnt < SW'(h_active));
   assign in_sync  = (hcnt >= sync_lo) && (hcnt < sync_hi);
   assign hpos     = hcnt[CW-1:0];

   always_ff @(posedge clk) begin
      if (rst)           hcnt <= '0;
      else if (line_end) hcnt <= '0;
      else               hcnt <= hcnt + SW'(1);
   end

   // R1: a line boundary always returns the column to zero.
   a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
      line_end |=> (hpos == '0) && in_act);

endmodule

// File: rtl/vrr_frame_seq.sv
module vrr_frame_seq
   import vrr_pkg::*;
#(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          line_end,
   input  logic          frame_ready,
   input  logic [CW-1:0] v_active,
   input  logic [CW-1:0] v_fp,
   input  logic [CW-1:0] v_sync,
   input  logic [CW-1:0] vbp_min,
   input  logic [CW-1:0] vbp_max,
   output vphase_e       phase,
   output logic [CW-1:0] lcnt,
   output logic [CW-1:0] bp_last,
   output logic          rpt
);

   localparam int NW = CW + 1;

   logic [NW-1:0] n_next;
   logic          ph_done;
   logic          bp_take;
   logic          bp_force;

   assign n_next = NW'(lcnt) + NW'(1);

   always_comb begin
      unique case (phase)
         VP_FRONT:  ph_done = (n_next >= NW'(v_fp));
         VP_SYNC:   ph_done = (n_next >= NW'(v_sync));
         VP_ACTIVE: ph_done = (n_next >= NW'(v_active));
         default:   ph_done = 1'b0;
      endcase
   end

   // Back porch exit: a ready frame once the minimum is met, or the cap.
   assign bp_take  = (n_next >= NW'(vbp_min)) && frame_ready;
   assign bp_force = (n_next >= NW'(vbp_max));

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= VP_FRONT;
         lcnt    <= '0;
         bp_last <= '0;
         rpt     <= 1'b0;
      end else if (line_end) begin
         unique case (phase)
            VP_FRONT: begin
               if (ph_done) begin
                  phase <= VP_SYNC;
                  lcnt  <= '0;
               end else begin
                  lcnt  <= n_next[CW-1:0];
               end
            end
            VP_SYNC: begin
               if (ph_done) begin
                  phase <= VP_BACK;
                  lcnt  <= '0;
               end else begin
                  lcnt  <= n_next[CW-1:0];
               end
            end
            VP_BACK: begin
               if (bp_take || bp_force) begin
                  phase   <= VP_ACTIVE;
                  lcnt    <= '0;
                  bp_last <= n_next[CW-1:0];
                  rpt     <= !bp_take;
               end else begin
                  lcnt    <= n_next[CW-1:0];
               end
            end
            default: begin
               rpt <= 1'b0;
               if (ph_done) begin
                  phase <= VP_FRONT;
                  lcnt  <= '0;
               end else begin
                  lcnt  <= n_next[CW-1:0];
               end
            end
         endcase
      end
   end

   // R5: the back porch never runs past its configured cap.
   a_r5_bp_cap: assert property (@(posedge clk) disable iff (rst)
      (phase == VP_BACK) |-> (NW'(lcnt) < NW'(vbp_max)));

   // R3: a back porch line that ends without readiness or cap keeps porching.
   a_r3_hold_porch: assert property (@(posedge clk) disable iff (rst)
      (phase == VP_BACK && line_end && !frame_ready && (n_next < NW'(vbp_max)))
      |=> (phase == VP_BACK));

endmodule

// File: rtl/vrr_sync_out.sv
module vrr_sync_out
   import vrr_pkg::*;
#(
   parameter int CW      = 12,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hs_pol,
   input  logic          vs_pol,
   input  vphase_e       phase,
   input  logic [CW-1:0] hpos,
   input  logic [CW-1:0] lcnt,
   input  logic          in_act,
   input  logic          in_sync,
   input  logic          rpt,
   input  logic [CW-1:0] bp_last,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [CW-1:0] px_x,
   output logic [CW-1:0] px_y,
   output logic          frame_start,
   output logic          repeat_frame,
   output logic [CW-1:0] bp_lines
);

   vflags_t       nf;
   logic [CW-1:0] nx;
   logic [CW-1:0] ny;

   always_comb begin
      nf.de  = (phase == VP_ACTIVE) && in_act;
      nf.hs  = hs_pol ? in_sync : !in_sync;
      nf.vs  = vs_pol ? (phase == VP_SYNC) : (phase != VP_SYNC);
      nf.fs  = nf.de && (hpos == '0) && (lcnt == '0);
      nf.rpt = rpt && (phase == VP_ACTIVE);
      nx     = nf.de ? hpos : '0;
      ny     = nf.de ? lcnt : '0;
   end

   generate
      if (OUT_REG) begin : g_reg
         vflags_t       qf;
         logic [CW-1:0] qx;
         logic [CW-1:0] qy;
         logic [CW-1:0] qb;
         always_ff @(posedge clk) begin
            if (rst) begin
               qf    <= VFLAGS_IDLE;
               qf.hs <= !hs_pol;
               qf.vs <= !vs_pol;
               qx    <= '0;
               qy    <= '0;
               qb    <= '0;
            end else begin
               qf <= nf;
               qx <= nx;
               qy <= ny;
               qb <= bp_last;
            end
         end
         assign de           = qf.de;
         assign hsync        = qf.hs;
         assign vsync        = qf.vs;
         assign frame_start  = qf.fs;
         assign repeat_frame = qf.rpt;
         assign px_x         = qx;
         assign px_y         = qy;
         assign bp_lines     = qb;
      end else begin : g_comb
         assign de           = nf.de;
         assign hsync        = nf.hs;
         assign vsync        = nf.vs;
         assign frame_start  = nf.fs;
         assign repeat_frame = nf.rpt;
         assign px_x         = nx;
         assign px_y         = ny;
         assign bp_lines     = bp_last;
      end
   endgenerate

endmodule

// File: rtl/vrr_raster_gen.sv
module vrr_raster_gen
   import vrr_pkg::*;
#(
   parameter int CW      = 12,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] cfg_h_active,
   input  logic [CW-1:0] cfg_h_fp,
   input  logic [CW-1:0] cfg_h_sync,
   input  logic [CW-1:0] cfg_h_bp,
   input  logic [CW-1:0] cfg_v_active,
   input  logic [CW-1:0] cfg_v_fp,
   input  logic [CW-1:0] cfg_v_sync,
   input  logic [CW-1:0] cfg_vbp_min,
   input  logic [CW-1:0] cfg_vbp_max,
   input  logic          cfg_hs_pol,
   input  logic          cfg_vs_pol,
   input  logic          frame_ready,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [CW-1:0] px_x,
   output logic [CW-1:0] px_y,
   output logic          frame_start,
   output logic          repeat_frame,
   output logic [CW-1:0] bp_lines
);

   if (CW < 2 || CW > 24) begin : g_bad_cw
      $error("vrr_raster_gen: CW must lie in 2..24");
   end

   logic [CW-1:0] hpos;
   logic          line_end;
   logic          in_act;
   logic          in_sync;
   vphase_e       phase;
   logic [CW-1:0] lcnt;
   logic [CW-1:0] bp_last;
   logic          rpt;

   vrr_line_timer #(.CW(CW)) u_line (
      .clk      (clk),
      .rst      (rst),
      .h_active (cfg_h_active),
      .h_fp     (cfg_h_fp),
      .h_sync   (cfg_h_sync),
      .h_bp     (cfg_h_bp),
      .hpos     (hpos),
      .line_end (line_end),
      .in_act   (in_act),
      .in_sync  (in_sync)
   );

   vrr_frame_seq #(.CW(CW)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .line_end    (line_end),
      .frame_ready (frame_ready),
      .v_active    (cfg_v_active),
      .v_fp        (cfg_v_fp),
      .v_sync      (cfg_v_sync),
      .vbp_min     (cfg_vbp_min),
      .vbp_max     (cfg_vbp_max),
      .phase       (phase),
      .lcnt        (lcnt),
      .bp_last     (bp_last),
      .rpt         (rpt)
   );

   vrr_sync_out #(.CW(CW), .OUT_REG(OUT_REG)) u_out (
      .clk          (clk),
      .rst          (rst),
      .hs_pol       (cfg_hs_pol),
      .vs_pol       (cfg_vs_pol),
      .phase        (phase),
      .hpos         (hpos),
      .lcnt         (lcnt),
      .in_act       (in_act),
      .in_sync      (in_sync),
      .rpt          (rpt),
      .bp_last      (bp_last),
      .hsync        (hsync),
      .vsync        (vsync),
      .de           (de),
      .px_x         (px_x),
      .px_y         (px_y),
      .frame_start  (frame_start),
      .repeat_frame (repeat_frame),
      .bp_lines     (bp_lines)
   );

   // R7: the frame marker lands on the raster origin with data-enable high.
   a_r7_fs_origin: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> (de && px_x == '0 && px_y == '0));

   // R5: a forced refresh always reports the capped porch length.
   a_r5_rpt_at_cap: assert property (@(posedge clk) disable iff (rst)
      repeat_frame |-> (bp_lines == cfg_vbp_max));

   // R2: vertical sync moves only while horizontal sync is inactive.
   a_r2_vs_line_aligned: assert property (@(posedge clk) disable iff (rst)
      (vsync != $past(vsync)) |-> (hsync == !cfg_hs_pol));

   // R8: coordinates stay inside the active window whenever data is enabled.
   a_r8_coord_bounds: assert property (@(posedge clk) disable iff (rst)
      de |-> ((px_x < cfg_h_active) && (px_y < cfg_v_active)));

endmodule

// File: tb/vrr_raster_gen_bench.sv
`timescale 1ns/1ps
module vrr_raster_gen_bench;

   localparam int CW  = 12;
   localparam int HA  = 16;
   localparam int HFP = 3;
   localparam int HSY = 4;
   localparam int HBP = 5;
   localparam int HT  = HA + HFP + HSY + HBP;
   localparam int VA  = 6;
   localparam int VFP = 2;
   localparam int VSY = 2;
   localparam int BMIN = 3;
   localparam int BMAX = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic hs_pol = 1'b1;
   logic vs_pol = 1'b1;
   logic ready = 1'b0;

   logic          hsync, vsync, de, frame_start, repeat_frame;
   logic [CW-1:0] px_x, px_y, bp_lines;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   vrr_raster_gen #(.CW(CW), .OUT_REG(1'b1)) u_vrr_raster_gen (
      .clk          (clk),
      .rst          (rst),
      .cfg_h_active (CW'(HA)),
      .cfg_h_fp     (CW'(HFP)),
      .cfg_h_sync   (CW'(HSY)),
      .cfg_h_bp     (CW'(HBP)),
      .cfg_v_active (CW'(VA)),
      .cfg_v_fp     (CW'(VFP)),
      .cfg_v_sync   (CW'(VSY)),
      .cfg_vbp_min  (CW'(BMIN)),
      .cfg_vbp_max  (CW'(BMAX)),
      .cfg_hs_pol   (hs_pol),
      .cfg_vs_pol   (vs_pol),
      .frame_ready  (ready),
      .hsync        (hsync),
      .vsync        (vsync),
      .de           (de),
      .px_x         (px_x),
      .px_y         (px_y),
      .frame_start  (frame_start),
      .repeat_frame (repeat_frame),
      .bp_lines     (bp_lines)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Scoreboard of expected frames
   int    q_bp[$];
   bit    q_rpt[$];
   string q_tag[$];

   function automatic bit vs_on();
      return (vsync == vs_pol);
   endfunction

   // Monitor
   int cyc = 0;
   int t_fs = 0, t_vr = 0, t_vf = 0;
   bit have_fs = 0, have_vf = 0, vs_prev = 0;
   int line_bad = 0;

   always @(negedge clk) begin
      if (rst) begin
         have_fs  = 0;
         have_vf  = 0;
         vs_prev  = 0;
         line_bad = 0;
      end else begin
         int i;
         bit hs_exp;
         cyc++;
         if (vs_on() && !vs_prev) begin
            t_vr = cyc;
            if (have_fs) chk((cyc - t_fs) == (VA + VFP) * HT, "R2 vsync rise", cyc - t_fs, (VA + VFP) * HT);
         end
         if (!vs_on() && vs_prev) begin
            chk((cyc - t_vr) == VSY * HT, "R2 vsync width", cyc - t_vr, VSY * HT);
            t_vf = cyc;
            have_vf = 1;
         end
         vs_prev = vs_on();
         if (frame_start) begin
            if (q_bp.size() == 0) begin
               chk(1'b0, "R7 unexpected frame_start", 1, 0);
            end else begin
               int eb;
               bit er;
               string tg;
               eb = q_bp.pop_front();
               er = q_rpt.pop_front();
               tg = q_tag.pop_front();
               chk(int'(bp_lines) == eb, {tg, " bp_lines"}, int'(bp_lines), eb);
               chk(repeat_frame == er, {tg, " repeat_frame"}, int'(repeat_frame), int'(er));
               if (have_vf) chk((cyc - t_vf) == eb * HT, {tg, " porch length"}, cyc - t_vf, eb * HT);
            end
            t_fs = cyc;
            have_fs = 1;
            line_bad = 0;
         end
         if (have_fs) begin
            i = cyc - t_fs;
            if (i < HT) begin
               hs_exp = (i >= HA + HFP) && (i < HA + HFP + HSY);
               if (de != (i < HA)) line_bad++;
               if (int'(px_x) != ((i < HA) ? i : 0)) line_bad++;
               if (px_y != '0) line_bad++;
               if ((hsync == hs_pol) != hs_exp) line_bad++;
               if (frame_start != (i == 0)) line_bad++;
               if (i == HT - 1) begin
                  chk(line_bad == 0, "R1 R8 R9 first line pattern", line_bad, 0);
               end
            end else if (i == HT) begin
               chk(de && px_x == '0 && int'(px_y) == 1, "R8 second line start", int'(px_y), 1);
               chk(repeat_frame == 1'b0, "R5 repeat only one line", int'(repeat_frame), 0);
            end
         end
      end
   end

   // Driver: modes 0 = ready mid-line n, 1 = early, 2 = never, 3 = glitch at g then ready at n
   task automatic wait_vs_fall();
      bit p;
      p = vs_on();
      forever begin
         @(negedge clk);
         if (p && !vs_on()) break;
         p = vs_on();
      end
   endtask

   task automatic wait_fs();
      do @(negedge clk); while (!frame_start);
   endtask

   task automatic drive_frame(input int mode, input int n, input int g, input string tag);
      int eb;
      bit er;
      case (mode)
         1:       begin eb = BMIN; er = 0; end
         2:       begin eb = BMAX; er = 1; end
         default: begin
            eb = (n < BMIN) ? BMIN : ((n > BMAX) ? BMAX : n);
            er = (n > BMAX);
         end
      endcase
      q_bp.push_back(eb);
      q_rpt.push_back(er);
      q_tag.push_back(tag);
      case (mode)
         1: begin
            ready = 1'b1;
            wait_fs();
            ready = 1'b0;
         end
         2: begin
            ready = 1'b0;
            wait_fs();
         end
         3: begin
            wait_vs_fall();
            repeat ((g - 1) * HT + HT / 2 - 1) @(negedge clk);
            ready = 1'b1;
            repeat (3) @(negedge clk);
            ready = 1'b0;
            repeat ((n - g) * HT - 2) @(negedge clk);
            ready = 1'b1;
            wait_fs();
            ready = 1'b0;
         end
         default: begin
            wait_vs_fall();
            repeat ((n - 1) * HT + HT / 2) @(negedge clk);
            ready = 1'b1;
            wait_fs();
            ready = 1'b0;
         end
      endcase
   endtask

   task automatic reset_phase(input bit hp, input bit vp);
      int cnt;
      rst = 1'b1;
      ready = 1'b0;
      hs_pol = hp;
      vs_pol = vp;
      repeat (5) @(negedge clk);
      // R10: all outputs idle under reset
      chk(de == 1'b0 && frame_start == 1'b0 && repeat_frame == 1'b0, "R10 idle flags",
          int'({de, frame_start, repeat_frame}), 0);
      chk(hsync == !hp && vsync == !vp, "R10 R9 sync inactive level", int'({hsync, vsync}), int'({!hp, !vp}));
      chk(px_x == '0 && px_y == '0 && bp_lines == '0, "R10 counts zero", int'(px_x | px_y | bp_lines), 0);
      rst = 1'b0;
      cnt = 0;
      do begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
      end while (vsync != vp && cnt < 2000);
      chk(cnt == VFP * HT + 1, "R10 first vsync after reset", cnt, VFP * HT + 1);
   endtask

   initial begin
      reset_phase(1'b1, 1'b1);
      drive_frame(0, 5, 0, "R3 ready at line 5");
      drive_frame(1, 0, 0, "R4 ready early");
      drive_frame(0, 1, 0, "R4 ready below minimum");
      drive_frame(0, BMIN, 0, "R3 ready at minimum");
      drive_frame(0, BMAX, 0, "R5 ready at maximum");
      drive_frame(2, 0, 0, "R5 never ready");
      drive_frame(3, 6, 4, "R6 glitch ignored");
      drive_frame(0, 4, 0, "R3 after repeat");
      repeat (HT + 4) @(negedge clk);
      reset_phase(1'b0, 1'b0);
      drive_frame(0, 4, 0, "R9 low polarity ready at 4");
      drive_frame(2, 0, 0, "R5 R9 low polarity never ready");
      drive_frame(1, 0, 0, "R4 R9 low polarity early");
      repeat (HT + 4) @(negedge clk);
      chk(q_bp.size() == 0, "R7 frames outstanding", q_bp.size(), 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule